// File: doc/BRIEF.md
# Virtual Command-Register Write Emulation Dispatcher

This block sits behind the guest-write path of a virtualized interrupt-controller register page. Once a guest store to that page has fully retired, the write is handed to the dispatcher as a one-cycle request. The request carries the byte offset within the page, a flag marking writes that came through the model-specific-register path for the self-interrupt register, the current low and high words of the interrupt command register image, and the virtual-interrupt-delivery enable. The dispatcher then produces exactly one of three results. It can return a patched high command word. It can raise a virtual self-interrupt carrying an 8-bit vector. Or it can request a trap-like hypervisor exit with the reason code for this kind of write and a 12-bit qualification.

Pending emulation holds off system-management and INIT events until it has been dispatched. Interrupt-enable state and interrupt shadows have no influence on it. A fault delivered in the window between the write and the emulation only postpones the work (defer input). A hypervisor exit taken in that window throws the work away (cancel input).

The control is a three-state machine. IDLE goes to PENDING on an accepted request (ACCEPT). PENDING goes back to IDLE when cancel is high (DISCARD), stays in PENDING while defer is high (HOLD), and otherwise goes to DISPATCH (FIRE). DISPATCH always returns to IDLE after one cycle (RETIRE).

Top module: `vapic_wr_dispatch`

## Requirements
- R1: While reset is asserted and right after it is released, every strobe, every data output and `busy_o` are 0, and the machine is in IDLE.
- R2: A request accepted at clock edge k, with defer and cancel low, drives exactly one of `patch_o`, `sipi_o`, `trap_o` high for the single cycle after edge k+1. `busy_o` is high from edge k until edge k+2. Data outputs are zero whenever their own strobe is low.
- R3: A write at any offset from 310H to 313H returns `patch_o` with `patch_word_o` equal to the captured high command word with bits [23:0] cleared and bits [31:24] kept. No exit is requested, and the enable has no influence.
- R4: A write at offset exactly 300H with the enable set raises `sipi_o` when all of these hold: bits [10:8] are 000, bit 15 is 0, bits [19:18] are 01, bits 13, 16, 17 and [31:20] are 0, and the vector in bits [7:0] is at least 16. `sipi_vec_o` then carries bits [7:0]. Bits 11, 12 and 14 are don't-care.
- R5: A write at offset 300H requests an exit with qualification 300H when the enable is clear or any condition of R4 fails.
- R6: A write at any other page offset, including 301H–303H and 3F0H, requests an exit whose qualification equals the write offset.
- R7: Every exit presents the reason code 56 on `trap_reason_o`. The code is 0 when no exit is signalled.
- R8: A request with `wr_msr_i` set requests an exit with qualification 3F0H, whatever the offset input is.
- R9: While PENDING, a high `defer_i` (with cancel low) keeps the machine in PENDING with no result. The result is produced in the cycle after the edge at which defer is seen low.
- R10: While PENDING, a high `cancel_i` returns the machine to IDLE with no result, even if defer is also high.
- R11: While `busy_o` is high, `smi_take_o` and `init_take_o` are 0. While idle, a pending SMI is taken in preference to a pending INIT.
- R12: The offset, path flag, enable and both command words are sampled at acceptance. Later changes to them do not alter the result.
- R13: A request arriving while the machine is busy is ignored. It produces no result of its own and does not alter the result of the request in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_done_i | input | 1 | A completed page write awaits emulation (one-cycle request) |
| wr_ofs_i | input | 12 | Byte offset of the write within the page |
| wr_msr_i | input | 1 | Write came through the self-interrupt register MSR path |
| vid_en_i | input | 1 | Virtual-interrupt delivery enabled |
| cmd_lo_i | input | 32 | Low command register image |
| cmd_hi_i | input | 32 | High command register image |
| defer_i | input | 1 | A fault is being delivered; postpone emulation |
| cancel_i | input | 1 | An exit occurred before emulation; discard it |
| evt_smi_i | input | 1 | System-management event pending |
| evt_init_i | input | 1 | INIT event pending |
| patch_o | output | 1 | Patched high command word valid |
| patch_word_o | output | 32 | Patched high command word |
| sipi_o | output | 1 | Virtual self-interrupt request |
| sipi_vec_o | output | 8 | Self-interrupt vector |
| trap_o | output | 1 | Trap-like exit request |
| trap_reason_o | output | 16 | Basic exit reason |
| trap_qual_o | output | 12 | Exit qualification |
| busy_o | output | 1 | Emulation pending or dispatching |
| smi_take_o | output | 1 | SMI may be taken this cycle |
| init_take_o | output | 1 | INIT may be taken this cycle |

## Verification
The bound checker checks, on every cycle, the properties that do not depend on which write is in flight. These are: at most one result at a time, one-cycle pulses that only follow a busy period, cleared low bits on any patch, a legal vector on any self-interrupt, the fixed exit reason, defer holding and cancel discarding a pending request, and events being blocked while busy. Only the bench's scenarios show that each offset and each command-word pattern maps to the right result and qualification. They also show that inputs are sampled at acceptance and that a second request arriving while busy leaves the first one's result untouched.

// File: rtl/vapic_pkg.sv
package vapic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PENDING  = 2'd1,
        ST_DISPATCH = 2'd2
    } emu_state_t;

    typedef enum logic [1:0] {
        WK_CMD_HI   = 2'd0,
        WK_CMD_LO   = 2'd1,
        WK_MSR_SELF = 2'd2,
        WK_OTHER    = 2'd3
    } wr_kind_t;

endpackage

// File: rtl/vapic_ofs_decode.sv
module vapic_ofs_decode
    import vapic_pkg::*;
#(
    parameter int               OFS_W      = 12,
    parameter logic [OFS_W-1:0] CMD_LO_OFS = 12'h300,
    parameter logic [OFS_W-1:0] CMD_HI_OFS = 12'h310
) (
    input  logic [OFS_W-1:0] ofs_i,
    input  logic             msr_i,
    output wr_kind_t         kind_o
);
    // the high command word spans one 32-bit slot: any byte in it counts
    localparam int WORD_LSB = 2;

    always_comb begin
        if (msr_i) begin
            kind_o = WK_MSR_SELF;
        end else if (ofs_i[OFS_W-1:WORD_LSB] == CMD_HI_OFS[OFS_W-1:WORD_LSB]) begin
            kind_o = WK_CMD_HI;
        end else if (ofs_i == CMD_LO_OFS) begin
            kind_o = WK_CMD_LO;
        end else begin
            kind_o = WK_OTHER;
        end
    end

endmodule

// File: rtl/vapic_sipi_qualify.sv
module vapic_sipi_qualify #(
    parameter int               REG_W    = 32,
    parameter int               VEC_W    = 8,
    parameter int               MIN_VEC  = 16,
    // checked fields: mode [10:8], bit 13, trigger 15, [17:16], shorthand [19:18], [31:20]
    parameter logic [REG_W-1:0] CHK_MASK = 32'hFFFF_A700,
    parameter logic [REG_W-1:0] CHK_VAL  = 32'h0004_0000
) (
    input  logic [REG_W-1:0] cmd_i,
    input  logic             vid_en_i,
    output logic             ok_o,
    output logic [VEC_W-1:0] vec_o
);
    localparam logic [VEC_W-1:0] VEC_FLOOR = VEC_W'(MIN_VEC);

    logic fields_ok;
    logic vec_ok;

    assign vec_o     = cmd_i[VEC_W-1:0];
    assign fields_ok = ((cmd_i & CHK_MASK) == CHK_VAL);
    assign vec_ok    = (vec_o >= VEC_FLOOR);
    assign ok_o      = vid_en_i && fields_ok && vec_ok;

endmodule

// File: rtl/vapic_emul_fsm.sv
module vapic_emul_fsm
    import vapic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       defer_i,
    input  logic       cancel_i,
    output emu_state_t state_o,
    output logic       accept_o,
    output logic       fire_o
);
    emu_state_t st_q;
    emu_state_t st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions: ACCEPT, DISCARD, HOLD, FIRE, RETIRE
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (req_i) st_d = ST_PENDING;
            end
            ST_PENDING: begin
                if (cancel_i)      st_d = ST_IDLE;
                else if (!defer_i) st_d = ST_DISPATCH;
            end
            ST_DISPATCH: begin
                st_d = ST_IDLE;
            end
            default: begin
                st_d = ST_IDLE;
            end
        endcase
    end

    assign state_o  = st_q;
    assign accept_o = (st_q == ST_IDLE) && req_i;
    assign fire_o   = (st_q == ST_PENDING) && !cancel_i && !defer_i;

endmodule

// File: rtl/vapic_action_reg.sv
module vapic_action_reg
    import vapic_pkg::*;
#(
    parameter int                OFS_W          = 12,
    parameter int                REG_W          = 32,
    parameter int                VEC_W          = 8,
    parameter int                RSN_W          = 16,
    parameter int                CLR_W          = 24,
    parameter logic [RSN_W-1:0]  RSN_APIC_WRITE = 16'd56,
    parameter logic [OFS_W-1:0]  MSR_QUAL       = 12'h3F0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  wr_kind_t         kind_i,
    input  logic             sipi_ok_i,
    input  logic [VEC_W-1:0] sipi_vec_i,
    input  logic [REG_W-1:0] cmd_hi_i,
    input  logic [OFS_W-1:0] ofs_i,
    output logic             patch_o,
    output logic [REG_W-1:0] patch_word_o,
    output logic             sipi_o,
    output logic [VEC_W-1:0] sipi_vec_o,
    output logic             trap_o,
    output logic [RSN_W-1:0] trap_reason_o,
    output logic [OFS_W-1:0] trap_qual_o
);
    localparam logic [REG_W-1:0] KEEP_MASK = ~((REG_W'(1) << CLR_W) - REG_W'(1));

    // output register: results live for exactly the DISPATCH cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            patch_o       <= 1'b0;
            patch_word_o  <= '0;
            sipi_o        <= 1'b0;
            sipi_vec_o    <= '0;
            trap_o        <= 1'b0;
            trap_reason_o <= '0;
            trap_qual_o   <= '0;
        end else begin
            patch_o       <= 1'b0;
            patch_word_o  <= '0;
            sipi_o        <= 1'b0;
            sipi_vec_o    <= '0;
            trap_o        <= 1'b0;
            trap_reason_o <= '0;
            trap_qual_o   <= '0;
            if (fire_i) begin
                unique case (kind_i)
                    WK_CMD_HI: begin
                        patch_o      <= 1'b1;
                        patch_word_o <= cmd_hi_i & KEEP_MASK;
                    end
                    WK_CMD_LO: begin
                        if (sipi_ok_i) begin
                            sipi_o     <= 1'b1;
                            sipi_vec_o <= sipi_vec_i;
                        end else begin
                            trap_o        <= 1'b1;
                            trap_reason_o <= RSN_APIC_WRITE;
                            trap_qual_o   <= ofs_i;
                        end
                    end
                    WK_MSR_SELF: begin
                        trap_o        <= 1'b1;
                        trap_reason_o <= RSN_APIC_WRITE;
                        trap_qual_o   <= MSR_QUAL;
                    end
                    WK_OTHER: begin
                        trap_o        <= 1'b1;
                        trap_reason_o <= RSN_APIC_WRITE;
                        trap_qual_o   <= ofs_i;
                    end
                    default: begin
                        trap_o <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/vapic_wr_dispatch.sv
module vapic_wr_dispatch
    import vapic_pkg::*;
#(
    parameter int OFS_W          = 12,
    parameter int REG_W          = 32,
    parameter int VEC_W          = 8,
    parameter int RSN_W          = 16,
    parameter int CLR_W          = 24,
    parameter int MIN_VEC        = 16,
    parameter int RSN_APIC_WRITE = 56,
    parameter int CMD_LO_OFS     = 'h300,
    parameter int CMD_HI_OFS     = 'h310,
    parameter int MSR_QUAL       = 'h3F0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_done_i,
    input  logic [OFS_W-1:0] wr_ofs_i,
    input  logic             wr_msr_i,
    input  logic             vid_en_i,
    input  logic [REG_W-1:0] cmd_lo_i,
    input  logic [REG_W-1:0] cmd_hi_i,
    input  logic             defer_i,
    input  logic             cancel_i,
    input  logic             evt_smi_i,
    input  logic             evt_init_i,
    output logic             patch_o,
    output logic [REG_W-1:0] patch_word_o,
    output logic             sipi_o,
    output logic [VEC_W-1:0] sipi_vec_o,
    output logic             trap_o,
    output logic [RSN_W-1:0] trap_reason_o,
    output logic [OFS_W-1:0] trap_qual_o,
    output logic             busy_o,
    output logic             smi_take_o,
    output logic             init_take_o
);
    localparam logic [OFS_W-1:0] LO_OFS  = OFS_W'(CMD_LO_OFS);
    localparam logic [OFS_W-1:0] HI_OFS  = OFS_W'(CMD_HI_OFS);
    localparam logic [OFS_W-1:0] MSR_Q   = OFS_W'(MSR_QUAL);
    localparam logic [RSN_W-1:0] RSN_VAL = RSN_W'(RSN_APIC_WRITE);

    emu_state_t       state;
    logic             accept;
    logic             fire;
    wr_kind_t         kind;
    logic             sipi_ok;
    logic [VEC_W-1:0] sipi_vec;

    // snapshot taken on ACCEPT
    logic [OFS_W-1:0] ofs_q;
    logic             msr_q;
    logic             vid_q;
    logic [REG_W-1:0] lo_q;
    logic [REG_W-1:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_q <= '0;
            msr_q <= 1'b0;
            vid_q <= 1'b0;
            lo_q  <= '0;
            hi_q  <= '0;
        end else if (accept) begin
            ofs_q <= wr_ofs_i;
            msr_q <= wr_msr_i;
            vid_q <= vid_en_i;
            lo_q  <= cmd_lo_i;
            hi_q  <= cmd_hi_i;
        end
    end

    vapic_emul_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (wr_done_i),
        .defer_i  (defer_i),
        .cancel_i (cancel_i),
        .state_o  (state),
        .accept_o (accept),
        .fire_o   (fire)
    );

    vapic_ofs_decode #(
        .OFS_W      (OFS_W),
        .CMD_LO_OFS (LO_OFS),
        .CMD_HI_OFS (HI_OFS)
    ) u_decode (
        .ofs_i  (ofs_q),
        .msr_i  (msr_q),
        .kind_o (kind)
    );

    vapic_sipi_qualify #(
        .REG_W   (REG_W),
        .VEC_W   (VEC_W),
        .MIN_VEC (MIN_VEC)
    ) u_qual (
        .cmd_i    (lo_q),
        .vid_en_i (vid_q),
        .ok_o     (sipi_ok),
        .vec_o    (sipi_vec)
    );

    vapic_action_reg #(
        .OFS_W          (OFS_W),
        .REG_W          (REG_W),
        .VEC_W          (VEC_W),
        .RSN_W          (RSN_W),
        .CLR_W          (CLR_W),
        .RSN_APIC_WRITE (RSN_VAL),
        .MSR_QUAL       (MSR_Q)
    ) u_act (
        .clk           (clk),
        .rst_n         (rst_n),
        .fire_i        (fire),
        .kind_i        (kind),
        .sipi_ok_i     (sipi_ok),
        .sipi_vec_i    (sipi_vec),
        .cmd_hi_i      (hi_q),
        .ofs_i         (ofs_q),
        .patch_o       (patch_o),
        .patch_word_o  (patch_word_o),
        .sipi_o        (sipi_o),
        .sipi_vec_o    (sipi_vec_o),
        .trap_o        (trap_o),
        .trap_reason_o (trap_reason_o),
        .trap_qual_o   (trap_qual_o)
    );

    // event ordering: emulation outranks SMI, SMI outranks INIT
    assign busy_o      = (state != ST_IDLE);
    assign smi_take_o  = evt_smi_i && !busy_o;
    assign init_take_o = evt_init_i && !busy_o && !evt_smi_i;

endmodule

// File: rtl/vapic_wr_dispatch_chk.sv
module vapic_wr_dispatch_chk #(
    parameter int REG_W          = 32,
    parameter int VEC_W          = 8,
    parameter int RSN_W          = 16,
    parameter int CLR_W          = 24,
    parameter int MIN_VEC        = 16,
    parameter int RSN_APIC_WRITE = 56
) (
    input logic             clk,
    input logic             rst_n,
    input logic             defer_i,
    input logic             cancel_i,
    input logic             patch_o,
    input logic [REG_W-1:0] patch_word_o,
    input logic             sipi_o,
    input logic [VEC_W-1:0] sipi_vec_o,
    input logic             trap_o,
    input logic [RSN_W-1:0] trap_reason_o,
    input logic             busy_o,
    input logic             smi_take_o,
    input logic             init_take_o
);
    logic act;
    assign act = patch_o || sipi_o || trap_o;

    p_one_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({patch_o, sipi_o, trap_o}));

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        act |=> !act);

    p_result_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        act |-> (busy_o && $past(busy_o)));

    p_patch_low_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        patch_o |-> (patch_word_o[CLR_W-1:0] == '0));

    p_sipi_vector_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sipi_o |-> (sipi_vec_o >= VEC_W'(MIN_VEC)));

    p_trap_reason_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (trap_reason_o == RSN_W'(RSN_APIC_WRITE)));

    p_defer_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !act && defer_i && !cancel_i) |=> (busy_o && !act));

    p_cancel_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !act && cancel_i) |=> (!busy_o && !act));

    p_events_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (!smi_take_o && !init_take_o));

    p_smi_before_init_r11: assert property (@(posedge clk) disable iff (!rst_n)
        smi_take_o |-> !init_take_o);

endmodule

bind vapic_wr_dispatch vapic_wr_dispatch_chk #(
    .REG_W          (REG_W),
    .VEC_W          (VEC_W),
    .RSN_W          (RSN_W),
    .CLR_W          (CLR_W),
    .MIN_VEC        (MIN_VEC),
    .RSN_APIC_WRITE (RSN_APIC_WRITE)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .defer_i       (defer_i),
    .cancel_i      (cancel_i),
    .patch_o       (patch_o),
    .patch_word_o  (patch_word_o),
    .sipi_o        (sipi_o),
    .sipi_vec_o    (sipi_vec_o),
    .trap_o        (trap_o),
    .trap_reason_o (trap_reason_o),
    .busy_o        (busy_o),
    .smi_take_o    (smi_take_o),
    .init_take_o   (init_take_o)
);

// File: tb/vapic_wr_dispatch_tb.sv
module vapic_wr_dispatch_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_done_i = 1'b0;
    logic [11:0] wr_ofs_i = '0;
    logic        wr_msr_i = 1'b0;
    logic        vid_en_i = 1'b0;
    logic [31:0] cmd_lo_i = '0;
    logic [31:0] cmd_hi_i = '0;
    logic        defer_i = 1'b0;
    logic        cancel_i = 1'b0;
    logic        evt_smi_i = 1'b0;
    logic        evt_init_i = 1'b0;
    logic        patch_o;
    logic [31:0] patch_word_o;
    logic        sipi_o;
    logic [7:0]  sipi_vec_o;
    logic        trap_o;
    logic [15:0] trap_reason_o;
    logic [11:0] trap_qual_o;
    logic        busy_o;
    logic        smi_take_o;
    logic        init_take_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    vapic_wr_dispatch u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_done_i     (wr_done_i),
        .wr_ofs_i      (wr_ofs_i),
        .wr_msr_i      (wr_msr_i),
        .vid_en_i      (vid_en_i),
        .cmd_lo_i      (cmd_lo_i),
        .cmd_hi_i      (cmd_hi_i),
        .defer_i       (defer_i),
        .cancel_i      (cancel_i),
        .evt_smi_i     (evt_smi_i),
        .evt_init_i    (evt_init_i),
        .patch_o       (patch_o),
        .patch_word_o  (patch_word_o),
        .sipi_o        (sipi_o),
        .sipi_vec_o    (sipi_vec_o),
        .trap_o        (trap_o),
        .trap_reason_o (trap_reason_o),
        .trap_qual_o   (trap_qual_o),
        .busy_o        (busy_o),
        .smi_take_o    (smi_take_o),
        .init_take_o   (init_take_o)
    );

    // result strobes {patch, sipi, trap}
    localparam logic [2:0] A_NONE  = 3'b000;
    localparam logic [2:0] A_PATCH = 3'b100;
    localparam logic [2:0] A_SIPI  = 3'b010;
    localparam logic [2:0] A_TRAP  = 3'b001;

    typedef struct packed {
        logic        msr;
        logic [11:0] ofs;
        logic        vid;
        logic [31:0] lo;
        logic [31:0] hi;
        logic [2:0]  act;
        logic [7:0]  vec;
        logic [11:0] qual;
        logic [31:0] pw;
    } row_t;

    localparam int NROWS = 18;
    localparam row_t TBL [NROWS] = '{
        '{1'b0, 12'h310, 1'b1, 32'h0004_0041, 32'hAB12_3456, A_PATCH, 8'h00, 12'h000, 32'hAB00_0000},
        '{1'b0, 12'h313, 1'b1, 32'h0004_0041, 32'hFFFF_FFFF, A_PATCH, 8'h00, 12'h000, 32'hFF00_0000},
        '{1'b0, 12'h311, 1'b0, 32'h0000_0000, 32'h1234_5678, A_PATCH, 8'h00, 12'h000, 32'h1200_0000},
        '{1'b0, 12'h300, 1'b1, 32'h0004_0041, 32'hDEAD_BEEF, A_SIPI,  8'h41, 12'h000, 32'h0},
        '{1'b0, 12'h300, 1'b1, 32'h0004_0010, 32'hDEAD_BEEF, A_SIPI,  8'h10, 12'h000, 32'h0},
        '{1'b0, 12'h300, 1'b1, 32'h0004_5841, 32'hDEAD_BEEF, A_SIPI,  8'h41, 12'h000, 32'h0},
        '{1'b0, 12'h300, 1'b1, 32'h0004_000F, 32'hDEAD_BEEF, A_TRAP,  8'h00, 12'h300, 32'h0},
        '{1'b0, 12'h300, 1'b0, 32'h0004_0041, 32'hDEAD_BEEF, A_TRAP,  8'h00, 12'h300, 32'h0},
        '{1'b0, 12'h300, 1'b1, 32'h0004_0141, 32'hDEAD_BEEF, A_TRAP,  8'h00, 12'h300, 32'h0},
        '{1'b0, 12'h300, 1'b1, 32'h0004_8041, 32'hDEAD_BEEF, A_TRAP,  8'h00, 12'h300, 32'h0},
        '{1'b0, 12'h300, 1'b1, 32'h000C_0041, 32'hDEAD_BEEF, A_TRAP,  8'h00, 12'h300, 32'h0},
        '{1'b0, 12'h300, 1'b1, 32'h0104_0041, 32'hDEAD_BEEF, A_TRAP,  8'h00, 12'h300, 32'h0},
        '{1'b0, 12'h300, 1'b1, 32'h0004_2041, 32'hDEAD_BEEF, A_TRAP,  8'h00, 12'h300, 32'h0},
        '{1'b0, 12'h301, 1'b1, 32'h0004_0041, 32'hDEAD_BEEF, A_TRAP,  8'h00, 12'h301, 32'h0},
        '{1'b0, 12'h314, 1'b1, 32'h0004_0041, 32'hDEAD_BEEF, A_TRAP,  8'h00, 12'h314, 32'h0},
        '{1'b0, 12'h080, 1'b1, 32'h0004_0041, 32'hDEAD_BEEF, A_TRAP,  8'h00, 12'h080, 32'h0},
        '{1'b0, 12'h3F0, 1'b1, 32'h0004_0041, 32'hDEAD_BEEF, A_TRAP,  8'h00, 12'h3F0, 32'h0},
        '{1'b1, 12'h300, 1'b1, 32'h0004_0041, 32'hDEAD_BEEF, A_TRAP,  8'h00, 12'h3F0, 32'h0}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] outs();
        return {9'b0, patch_o, sipi_o, trap_o, sipi_vec_o, trap_qual_o, patch_word_o};
    endfunction

    function automatic logic [63:0] expect_outs(input logic [2:0] a, input logic [7:0] v,
                                                input logic [11:0] q, input logic [31:0] w);
        return {9'b0, a, v, q, w};
    endfunction

    // drive a request at the current negedge; returns at the next negedge (machine in PENDING)
    task automatic start_req(input logic msr, input logic [11:0] ofs, input logic vid,
                             input logic [31:0] lo, input logic [31:0] hi);
        wr_msr_i  = msr;
        wr_ofs_i  = ofs;
        vid_en_i  = vid;
        cmd_lo_i  = lo;
        cmd_hi_i  = hi;
        wr_done_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_done_i = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        string tag;
        // R1: reset values while reset is held
        repeat (3) @(negedge clk);
        check("R1 in reset", {outs(), 52'b0}, 64'b0);
        check("R1 busy in reset", {63'b0, busy_o}, 64'b0);
        rst_n = 1'b1;
        step();
        check("R1 after release", {outs(), 52'b0}, 64'b0);

        // table walk: R3 R4 R5 R6 R8 results, R7 reason, R2 pulse width
        for (int i = 0; i < NROWS; i++) begin
            start_req(TBL[i].msr, TBL[i].ofs, TBL[i].vid, TBL[i].lo, TBL[i].hi);
            check("R2 pending busy", {63'b0, busy_o}, 64'd1);
            step();
            if (TBL[i].act == A_PATCH)      tag = "R3";
            else if (TBL[i].act == A_SIPI)  tag = "R4";
            else if (TBL[i].msr)            tag = "R8";
            else if (TBL[i].ofs == 12'h300) tag = "R5";
            else                            tag = "R6";
            check($sformatf("%s row %0d", tag, i), outs(),
                  expect_outs(TBL[i].act, TBL[i].vec, TBL[i].qual, TBL[i].pw));
            check($sformatf("R7 row %0d", i), {48'b0, trap_reason_o},
                  (TBL[i].act == A_TRAP) ? 64'd56 : 64'd0);
            step();
            check($sformatf("R2 pulse end row %0d", i), {outs()[63:52], 51'b0, busy_o},
                  {A_NONE == 3'b0 ? 12'b0 : 12'b0, 52'b0});
        end

        // R9: defer holds for three cycles, then fires
        start_req(1'b0, 12'h300, 1'b1, 32'h0004_0041, 32'h0);
        defer_i = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step();
            check("R9 held", {outs()[63:52], 51'b0, busy_o}, 64'd1);
        end
        defer_i = 1'b0;
        step();
        check("R9 fires after defer", outs(), expect_outs(A_SIPI, 8'h41, 12'h0, 32'h0));
        step();

        // R10: cancel (with defer also high) discards
        start_req(1'b0, 12'h080, 1'b1, 32'h0, 32'h0);
        cancel_i = 1'b1;
        defer_i  = 1'b1;
        step();
        cancel_i = 1'b0;
        defer_i  = 1'b0;
        check("R10 discarded", {outs()[63:52], 51'b0, busy_o}, 64'd0);
        step();
        check("R10 no late result", {outs()[63:52], 52'b0}, 64'd0);

        // R11: event ordering
        evt_smi_i  = 1'b1;
        evt_init_i = 1'b1;
        #1;
        check("R11 idle smi first", {62'b0, smi_take_o, init_take_o}, 64'b10);
        evt_smi_i = 1'b0;
        #1;
        check("R11 idle init", {62'b0, smi_take_o, init_take_o}, 64'b01);
        @(negedge clk);
        start_req(1'b0, 12'h310, 1'b1, 32'h0, 32'h5500_00AA);
        evt_smi_i = 1'b1;
        #1;
        check("R11 busy holds events", {62'b0, smi_take_o, init_take_o}, 64'b00);
        step();
        check("R11 dispatch holds events", {62'b0, smi_take_o, init_take_o}, 64'b00);
        evt_smi_i  = 1'b0;
        evt_init_i = 1'b0;
        step();

        // R12: inputs sampled at acceptance
        start_req(1'b0, 12'h300, 1'b1, 32'h0004_0041, 32'h0);
        cmd_lo_i = 32'hFFFF_FFFF;
        vid_en_i = 1'b0;
        wr_ofs_i = 12'h123;
        wr_msr_i = 1'b1;
        step();
        check("R12 snapshot", outs(), expect_outs(A_SIPI, 8'h41, 12'h0, 32'h0));
        wr_msr_i = 1'b0;
        step();

        // R13: a request while busy is ignored
        start_req(1'b0, 12'h300, 1'b1, 32'h0004_0041, 32'h0);
        wr_done_i = 1'b1;
        wr_ofs_i  = 12'h310;
        cmd_hi_i  = 32'hFFFF_FFFF;
        defer_i   = 1'b1;
        step();
        wr_done_i = 1'b0;
        defer_i   = 1'b0;
        step();
        check("R13 first result kept", outs(), expect_outs(A_SIPI, 8'h41, 12'h0, 32'h0));
        step();
        check("R13 no extra result", {outs()[63:52], 51'b0, busy_o}, 64'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule